// File: doc/BRIEF.md
# Configurable Integer ALU with Barrel Shifter

This block is a purely combinational arithmetic unit. It takes two operands of equal width and returns one result of that same width. Three elaboration-time parameters fix what it computes. The first picks one of five operations: add, subtract, multiply, three-way compare or shift. The second says whether the operands are two's-complement or unsigned. The third says whether a shift fills vacated positions from an edge bit or rotates.

For the shift operation, the second operand carries both the shift amount and the direction. Its most significant bit always selects the direction: 0 shifts right and 1 shifts left. How the amount is read depends on the signed setting. In signed mode the amount is the magnitude of the operand read as a two's-complement value. In unsigned mode the amount is the operand's remaining low bits.

A parent design places one instance per operation it needs. It feeds the instance from its own registers, since the block has no clock and no state.

Top module: `int_alu`

## Requirements
- R1: With the add operation, the result is (a + b) modulo 2^WIDTH.
- R2: With the subtract operation, the result is (a - b) modulo 2^WIDTH.
- R3: With the multiply operation, the result is the low WIDTH bits of the product. The operands are read as two's-complement when the signed setting is on, and as unsigned otherwise.
- R4: With the compare operation and the signed setting off, the operands are compared as unsigned numbers.
- R5: With the compare operation and the signed setting on, the operands are compared as two's-complement numbers.
- R6: The compare result is one of three codes: 0 when a equals b, 1 when a is greater than b, and all ones when a is less than b.
- R7: Unsigned shift: bit WIDTH-1 of b gives the direction (0 right, 1 left). Bits WIDTH-2:0 of b give the count.
- R8: Signed shift: a non-negative b shifts right by b. A negative b shifts left by -b. The most negative b therefore shifts left by 2^(WIDTH-1).
- R9: Fill mode (rotate off): every vacated bit takes the value of a's end bit on the side being shifted away from. That is a[WIDTH-1] for a right shift and a[0] for a left shift.
- R10: Fill mode: a count of WIDTH or more gives a result in which every bit equals that fill bit.
- R11: Rotate mode: a is rotated in the chosen direction by the count modulo WIDTH, and no bit is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand; the value that is shifted |
| b_i | input | WIDTH | Second operand; for shifts, the direction and amount |
| res_o | output | WIDTH | Result of the configured operation |

## Verification
The bound checker tests four properties on every evaluation of the block:
- the inverse relations of add and subtract;
- that a zero multiplicand gives a zero product;
- that compare returns only the three legal codes, with zero exactly when the operands are equal;
- that rotation preserves the count of set bits, and that an over-range fill shift yields a uniform result.

Exact shift positions, the edge-fill values, the signed-versus-unsigned ordering of compare, and the modulo behaviour at a width that is not a power of two can only be shown by the bench. It sweeps every operand pair at widths 4 and 5 and compares each result against arithmetic computed in the bench.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_CMP = 3'd3,
    OP_SHF = 3'd4
  } alu_op_e;
endpackage

// File: rtl/int_alu_arith.sv
module int_alu_arith
  import int_alu_pkg::*;
#(
  parameter int      WIDTH        = 8,
  parameter alu_op_e OP           = OP_ADD,
  parameter bit      SIGNED_ARITH = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int PW = 2 * WIDTH;

  if (OP == OP_SUB) begin : g_sub
    assign res_o = a_i - b_i;
  end else if (OP == OP_MUL) begin : g_mul
    logic [PW-1:0] prod;
    if (SIGNED_ARITH) begin : g_smul
      logic signed [PW-1:0] sa, sb;
      assign sa   = PW'($signed(a_i));
      assign sb   = PW'($signed(b_i));
      assign prod = PW'(sa * sb);
    end else begin : g_umul
      assign prod = PW'(a_i) * PW'(b_i);
    end
    assign res_o = prod[WIDTH-1:0];
  end else begin : g_add
    assign res_o = a_i + b_i;
  end
endmodule

// File: rtl/int_alu_cmp.sv
module int_alu_cmp #(
  parameter int WIDTH        = 8,
  parameter bit SIGNED_ARITH = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  logic gt, eq;

  if (SIGNED_ARITH) begin : g_s
    assign gt = $signed(a_i) > $signed(b_i);
  end else begin : g_u
    assign gt = a_i > b_i;
  end
  assign eq = (a_i == b_i);

  always_comb begin
    if (eq)      res_o = '0;
    else if (gt) res_o = WIDTH'(1);
    else         res_o = '1;
  end
endmodule

// File: rtl/int_alu_shdec.sv
// Turns operand b into a direction, a stage amount and a saturation flag.
module int_alu_shdec #(
  parameter int WIDTH        = 8,
  parameter bit SIGNED_ARITH = 1'b0,
  parameter bit ROTATE       = 1'b0,
  localparam int LG          = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] b_i,
  output logic             left_o,
  output logic             sat_o,
  output logic [LG-1:0]    amt_o
);
  localparam logic [WIDTH-1:0] NW = WIDTH[WIDTH-1:0];
  logic [WIDTH-1:0] mag;

  assign left_o = b_i[WIDTH-1];

  if (SIGNED_ARITH) begin : g_smag
    assign mag = b_i[WIDTH-1] ? (~b_i + 1'b1) : b_i;
  end else begin : g_umag
    assign mag = {1'b0, b_i[WIDTH-2:0]};
  end

  if (ROTATE) begin : g_rot
    logic [WIDTH-1:0] md;
    assign md    = mag % NW;
    assign sat_o = 1'b0;
    assign amt_o = md[LG-1:0];
  end else begin : g_fill
    assign sat_o = (mag >= NW);
    assign amt_o = sat_o ? '0 : mag[LG-1:0];
  end
endmodule

// File: rtl/int_alu_barrel.sv
// Log-depth shifter; stage k moves by 2**k in the decoded direction.
module int_alu_barrel #(
  parameter int WIDTH  = 8,
  parameter bit ROTATE = 1'b0,
  localparam int LG    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             left_i,
  input  logic             sat_i,
  input  logic [LG-1:0]    amt_i,
  output logic [WIDTH-1:0] res_o
);
  logic             fill;
  logic [WIDTH-1:0] stg [0:LG];

  assign fill   = left_i ? a_i[0] : a_i[WIDTH-1];
  assign stg[0] = a_i;

  for (genvar k = 0; k < LG; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [WIDTH-1:0] shl, shr;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i + S < WIDTH) begin : g_r_in
        assign shr[i] = stg[k][i+S];
      end else if (ROTATE) begin : g_r_wrap
        assign shr[i] = stg[k][i+S-WIDTH];
      end else begin : g_r_fill
        assign shr[i] = fill;
      end
      if (i >= S) begin : g_l_in
        assign shl[i] = stg[k][i-S];
      end else if (ROTATE) begin : g_l_wrap
        assign shl[i] = stg[k][i-S+WIDTH];
      end else begin : g_l_fill
        assign shl[i] = fill;
      end
    end
    assign stg[k+1] = amt_i[k] ? (left_i ? shl : shr) : stg[k];
  end

  assign res_o = sat_i ? {WIDTH{fill}} : stg[LG];
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int      WIDTH        = 8,
  parameter alu_op_e OP           = OP_ADD,
  parameter bit      SIGNED_ARITH = 1'b0,
  parameter bit      ROTATE       = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int LG = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  if (OP == OP_CMP) begin : g_cmp
    int_alu_cmp #(.WIDTH(WIDTH), .SIGNED_ARITH(SIGNED_ARITH)) u_cmp (
      .a_i(a_i), .b_i(b_i), .res_o(res_o)
    );
  end else if (OP == OP_SHF) begin : g_shf
    logic          left, sat;
    logic [LG-1:0] amt;
    int_alu_shdec #(.WIDTH(WIDTH), .SIGNED_ARITH(SIGNED_ARITH), .ROTATE(ROTATE)) u_dec (
      .b_i(b_i), .left_o(left), .sat_o(sat), .amt_o(amt)
    );
    int_alu_barrel #(.WIDTH(WIDTH), .ROTATE(ROTATE)) u_bar (
      .a_i(a_i), .left_i(left), .sat_i(sat), .amt_i(amt), .res_o(res_o)
    );
  end else begin : g_arith
    int_alu_arith #(.WIDTH(WIDTH), .OP(OP), .SIGNED_ARITH(SIGNED_ARITH)) u_arith (
      .a_i(a_i), .b_i(b_i), .res_o(res_o)
    );
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int      WIDTH        = 8,
  parameter alu_op_e OP           = OP_ADD,
  parameter bit      SIGNED_ARITH = 1'b0,
  parameter bit      ROTATE       = 1'b0
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] res_o
);
  localparam logic [WIDTH-1:0] NW = WIDTH[WIDTH-1:0];
  logic [WIDTH-1:0] ucnt;

  assign ucnt = {1'b0, b_i[WIDTH-2:0]};

  always_comb begin
    if (OP == OP_ADD) begin
      assert_add_inverse_R1: assert (WIDTH'(res_o - b_i) == a_i)
        else $error("add result does not invert");
    end
    if (OP == OP_SUB) begin
      assert_sub_inverse_R2: assert (WIDTH'(res_o + b_i) == a_i)
        else $error("sub result does not invert");
    end
    if (OP == OP_MUL) begin
      assert_mul_zero_R3: assert (a_i != '0 || res_o == '0)
        else $error("zero multiplicand gave nonzero product");
    end
    if (OP == OP_CMP) begin
      assert_cmp_code_R6: assert (res_o == '0 || res_o == WIDTH'(1) || res_o == '1)
        else $error("illegal compare code");
      assert_cmp_eq_R4: assert ((res_o == '0) == (a_i == b_i))
        else $error("compare zero code mismatch");
    end
    if (OP == OP_SHF && ROTATE) begin
      assert_rot_keeps_bits_R11: assert ($countones(res_o) == $countones(a_i))
        else $error("rotate lost bits");
    end
    if (OP == OP_SHF && !ROTATE && !SIGNED_ARITH && ucnt >= NW) begin
      assert_sat_uniform_R10: assert (res_o == '0 || res_o == '1)
        else $error("saturated shift not uniform");
    end
  end
endmodule

bind int_alu int_alu_chk #(
  .WIDTH(WIDTH), .OP(OP), .SIGNED_ARITH(SIGNED_ARITH), .ROTATE(ROTATE)
) u_chk (
  .a_i(a_i), .b_i(b_i), .res_o(res_o)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  import int_alu_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic [3:0] a4, b4;
  logic [4:0] a5, b5;
  logic [3:0] r_add, r_sub, r_mulu, r_muls, r_cmpu, r_cmps;
  logic [3:0] r_su0, r_ss0, r_su1, r_ss1;
  logic [4:0] q_su0, q_ss0, q_su1, q_ss1;

  int_alu #(.WIDTH(4), .OP(OP_ADD))                      u_dut   (.a_i(a4), .b_i(b4), .res_o(r_add));
  int_alu #(.WIDTH(4), .OP(OP_SUB))                      u_sub   (.a_i(a4), .b_i(b4), .res_o(r_sub));
  int_alu #(.WIDTH(4), .OP(OP_MUL), .SIGNED_ARITH(1'b0)) u_mulu  (.a_i(a4), .b_i(b4), .res_o(r_mulu));
  int_alu #(.WIDTH(4), .OP(OP_MUL), .SIGNED_ARITH(1'b1)) u_muls  (.a_i(a4), .b_i(b4), .res_o(r_muls));
  int_alu #(.WIDTH(4), .OP(OP_CMP), .SIGNED_ARITH(1'b0)) u_cmpu  (.a_i(a4), .b_i(b4), .res_o(r_cmpu));
  int_alu #(.WIDTH(4), .OP(OP_CMP), .SIGNED_ARITH(1'b1)) u_cmps  (.a_i(a4), .b_i(b4), .res_o(r_cmps));
  int_alu #(.WIDTH(4), .OP(OP_SHF), .SIGNED_ARITH(1'b0), .ROTATE(1'b0)) u_su0 (.a_i(a4), .b_i(b4), .res_o(r_su0));
  int_alu #(.WIDTH(4), .OP(OP_SHF), .SIGNED_ARITH(1'b1), .ROTATE(1'b0)) u_ss0 (.a_i(a4), .b_i(b4), .res_o(r_ss0));
  int_alu #(.WIDTH(4), .OP(OP_SHF), .SIGNED_ARITH(1'b0), .ROTATE(1'b1)) u_su1 (.a_i(a4), .b_i(b4), .res_o(r_su1));
  int_alu #(.WIDTH(4), .OP(OP_SHF), .SIGNED_ARITH(1'b1), .ROTATE(1'b1)) u_ss1 (.a_i(a4), .b_i(b4), .res_o(r_ss1));
  int_alu #(.WIDTH(5), .OP(OP_SHF), .SIGNED_ARITH(1'b0), .ROTATE(1'b0)) u5_su0 (.a_i(a5), .b_i(b5), .res_o(q_su0));
  int_alu #(.WIDTH(5), .OP(OP_SHF), .SIGNED_ARITH(1'b1), .ROTATE(1'b0)) u5_ss0 (.a_i(a5), .b_i(b5), .res_o(q_ss0));
  int_alu #(.WIDTH(5), .OP(OP_SHF), .SIGNED_ARITH(1'b0), .ROTATE(1'b1)) u5_su1 (.a_i(a5), .b_i(b5), .res_o(q_su1));
  int_alu #(.WIDTH(5), .OP(OP_SHF), .SIGNED_ARITH(1'b1), .ROTATE(1'b1)) u5_ss1 (.a_i(a5), .b_i(b5), .res_o(q_ss1));

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sx(int v, int n);
    return (v >= (1 << (n - 1))) ? v - (1 << n) : v;
  endfunction

  function automatic int cmp_code(int x, int y, int n);
    if (x == y) return 0;
    if (x > y) return 1;
    return (1 << n) - 1;
  endfunction

  function automatic int shf_mag(int b, int n, bit sgn);
    int left = (b >> (n - 1)) & 1;
    if (sgn) return left ? (1 << n) - b : b;
    return b & ((1 << (n - 1)) - 1);
  endfunction

  function automatic int shf_exp(int a, int b, int n, bit sgn, bit rot);
    int mask = (1 << n) - 1;
    int left = (b >> (n - 1)) & 1;
    int mag  = shf_mag(b, n, sgn);
    int fill = left ? (a & 1) : ((a >> (n - 1)) & 1);
    int r;
    if (rot) begin
      int m = mag % n;
      if (left) r = ((a << m) | (a >> (n - m))) & mask;
      else      r = ((a >> m) | (a << (n - m))) & mask;
      return r;
    end
    if (mag >= n) return fill ? mask : 0;
    if (left) begin
      r = (a << mag) & mask;
      if (fill != 0) r = r | ((1 << mag) - 1);
    end else begin
      r = a >> mag;
      if (fill != 0) r = r | (mask & ~(mask >> mag));
    end
    return r;
  endfunction

  function automatic string shf_tag(int a, int b, int n, bit sgn, bit rot);
    int mag  = shf_mag(b, n, sgn);
    int left = (b >> (n - 1)) & 1;
    int fill = left ? (a & 1) : ((a >> (n - 1)) & 1);
    if (rot) return "R11";
    if (mag >= n) return "R10";
    if (fill != 0 && mag != 0) return "R9";
    return sgn ? "R8" : "R7";
  endfunction

  initial begin
    #(8 * 5000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    a4 = '0; b4 = '0; a5 = '0; b5 = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // zero operands: every instance reports zero
    chk("R1", "zero add", int'(r_add), 0);
    chk("R6", "zero cmp", int'(r_cmpu), 0);
    chk("R7", "zero shift", int'(r_su0), 0);

    // directed corners
    a4 = 4'b1001; b4 = 4'b1000;
    @(negedge clk);
    chk("R8", "signed most-negative shifts left 8 -> fill", int'(r_ss0), 15);
    chk("R7", "unsigned top bit left, count 0", int'(r_su0), 9);
    chk("R4", "unsigned 9 vs 8", int'(r_cmpu), 1);
    chk("R5", "signed -7 vs -8", int'(r_cmps), 1);

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        a4 = 4'(a); b4 = 4'(b);
        @(negedge clk);
        chk("R1", "add", int'(r_add), (a + b) & 15);
        chk("R2", "sub", int'(r_sub), (a - b) & 15);
        chk("R3", "mul unsigned", int'(r_mulu), (a * b) & 15);
        chk("R3", "mul signed", int'(r_muls), (sx(a, 4) * sx(b, 4)) & 15);
        chk("R4", "cmp unsigned", int'(r_cmpu), cmp_code(a, b, 4));
        chk("R5", "cmp signed", int'(r_cmps), cmp_code(sx(a, 4), sx(b, 4), 4));
        chk("R6", "cmp code set", int'(r_cmps == 4'd0 || r_cmps == 4'd1 || r_cmps == 4'hf), 1);
        chk(shf_tag(a, b, 4, 0, 0), "shift u fill", int'(r_su0), shf_exp(a, b, 4, 0, 0));
        chk(shf_tag(a, b, 4, 1, 0), "shift s fill", int'(r_ss0), shf_exp(a, b, 4, 1, 0));
        chk(shf_tag(a, b, 4, 0, 1), "shift u rot", int'(r_su1), shf_exp(a, b, 4, 0, 1));
        chk(shf_tag(a, b, 4, 1, 1), "shift s rot", int'(r_ss1), shf_exp(a, b, 4, 1, 1));
      end
    end

    // width 5: count modulo a non power of two
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        a5 = 5'(a); b5 = 5'(b);
        @(negedge clk);
        chk(shf_tag(a, b, 5, 0, 0), "w5 shift u fill", int'(q_su0), shf_exp(a, b, 5, 0, 0));
        chk(shf_tag(a, b, 5, 1, 0), "w5 shift s fill", int'(q_ss0), shf_exp(a, b, 5, 1, 0));
        chk(shf_tag(a, b, 5, 0, 1), "w5 shift u rot", int'(q_su1), shf_exp(a, b, 5, 0, 1));
        chk(shf_tag(a, b, 5, 1, 1), "w5 shift s rot", int'(q_ss1), shf_exp(a, b, 5, 1, 1));
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule